// File: doc/BRIEF.md
# Keyed XOR Encrypt and Verify Sequencer

This block is a small coprocessor sequencer that works on a byte-wide memory through a pointer the caller supplies. It holds a ten-byte secret and runs one of two commands. The encrypt command walks ten consecutive bytes upward from the pointer, XORs each with the matching secret byte and writes it back. The verify command walks the same window, ORs every byte-wise difference from the secret into an accumulator, and reports that accumulator. Zero means the window holds the secret.

Every XOR goes through an external ALU port with a request/acknowledge handshake. Its latency may change from one operation to the next, for example when a result cache sits in front of it. The sequencer stalls on each operation and counts the cycles of the whole run, so the reported run time shows how the ALU behaved. After a verify that matches, a stored payload is copied into memory just past the window. The copy is refused, and an error flag is raised, if it would run past the top of the address space. The secret and the payload are captured into the block's own registers when a command is accepted, so they are kept apart from whatever the caller drives afterwards.

Top module: `cipherSeq`

## Requirements
- R1: After reset, busy, done, memEn, memWe, aluReq and payloadErr are 0, and runCycles and verifyAcc are 0.
- R2: Encrypt replaces the memory byte at address (ptr+k) mod 4096 with that byte XOR secret byte k, for k = 0 to 9 in ascending order. Secret byte k is keyBits[8k+7:8k]. No other memory byte changes.
- R3: Verify sets verifyAcc to the OR over k = 0..9 of (secret byte k XOR memory byte at (ptr+k) mod 4096). It writes no byte of the window.
- R4: When verifyAcc ends at 0 and ptr+10+4 <= 4096, payload byte j (payloadBits[8j+7:8j]) is written to address ptr+10+j for j = 0..3, and payloadErr stays 0.
- R5: When verifyAcc ends at 0 and ptr+10+4 > 4096, no payload byte is written and payloadErr is 1. When verifyAcc ends nonzero, nothing is written and payloadErr is 0.
- R6: runCycles counts the cycles busy was high during the last run. Let d_k be the number of cycles aluReq waits before aluAck on byte k. Encrypt then takes 41 + sum(d_k) cycles. Verify takes 32 + sum(d_k), plus 4 more when the payload is written.
- R7: busy rises in the cycle after a command is accepted (cmdValid high while busy is low). busy falls after a single-cycle done pulse. A cmdValid that arrives while busy is high is ignored.
- R8: keyBits and payloadBits are sampled only when a command is accepted. Changing them during a run does not affect that run.
- R9: Each byte uses exactly one memory read and one ALU operation, and encrypt uses one write per byte. aluReq stays high with stable aluA and aluB until aluAck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, taken when idle |
| cmdVerify | input | 1 | 0 = encrypt, 1 = verify |
| cmdPtr | input | 12 | Start address of the ten-byte window |
| keyBits | input | 80 | Secret, byte k at bits 8k+7:8k |
| payloadBits | input | 32 | Payload, byte j at bits 8j+7:8j |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 12 | Memory address |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, one cycle after the read |
| aluReq | output | 1 | ALU request, held until acknowledged |
| aluA | output | 8 | ALU operand: the memory byte |
| aluB | output | 8 | ALU operand: the secret byte |
| aluAck | input | 1 | ALU response valid, may come in the request cycle |
| aluResult | input | 8 | XOR result |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| runCycles | output | 16 | Cycle count of the last run |
| verifyAcc | output | 8 | Difference accumulator of the last verify |
| payloadErr | output | 1 | Payload copy refused by the bounds check |

## Verification
The bench's ALU model picks each operation's latency from its operands, from zero wait up to three cycles. A sequencer that counted a fixed cost per byte, or that sampled the result one cycle too early, would then report a wrong runCycles or store wrong bytes. The windows cover the wrap past address 4095 during encrypt, and verify matches whose payload ends exactly at the top of memory or one byte beyond it. An off-by-one in the bounds compare either refuses a legal copy or writes across the wrap. Commands sent mid-run and secret changes mid-run are also tested. A design that re-accepted a command or read the live key would corrupt the memory image, which the bench compares against its own model.

// File: rtl/cipherSeqPkg.sv
package cipherSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_LATCH, ST_ALU, ST_WRITE, ST_CHECK, ST_PAYLOAD, ST_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    logic capByte;
    logic capRes;
    logic nextByte;
    logic nextPay;
    logic selPay;
    logic setErr;
    logic countEn;
  } seqStrobes_t;

  // status from datapath to control
  typedef struct packed {
    logic verifyMode;
    logic lastByte;
    logic lastPay;
    logic accZero;
    logic outOfRange;
  } seqFlags_t;

endpackage

// File: rtl/cipherSeqCtrl.sv
module cipherSeqCtrl
  import cipherSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        aluAck,
  input  seqFlags_t   flags,
  output seqStrobes_t stb,
  output logic        memEn,
  output logic        memWe,
  output logic        aluReq,
  output logic        busy,
  output logic        done
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    memEn     = 1'b0;
    memWe     = 1'b0;
    aluReq    = 1'b0;
    done      = 1'b0;
    busy      = (state != ST_IDLE);
    stb.countEn = busy;
    unique case (state)
      ST_IDLE: begin
        // R7: a command is only taken here
        if (cmdValid) begin
          stb.start = 1'b1;
          nextState = ST_READ;
        end
      end
      ST_READ: begin
        memEn     = 1'b1;
        nextState = ST_LATCH;
      end
      ST_LATCH: begin
        stb.capByte = 1'b1;
        nextState   = ST_ALU;
      end
      ST_ALU: begin
        aluReq = 1'b1;
        if (aluAck) begin
          stb.capRes = 1'b1;
          if (!flags.verifyMode) begin
            nextState = ST_WRITE;
          end else if (flags.lastByte) begin
            nextState = ST_CHECK;
          end else begin
            stb.nextByte = 1'b1;
            nextState    = ST_READ;
          end
        end
      end
      ST_WRITE: begin
        memEn = 1'b1;
        memWe = 1'b1;
        if (flags.lastByte) begin
          nextState = ST_DONE;
        end else begin
          stb.nextByte = 1'b1;
          nextState    = ST_READ;
        end
      end
      ST_CHECK: begin
        // R4/R5: payload only after a full match and inside memory
        if (!flags.accZero) begin
          nextState = ST_DONE;
        end else if (flags.outOfRange) begin
          stb.setErr = 1'b1;
          nextState  = ST_DONE;
        end else begin
          nextState = ST_PAYLOAD;
        end
      end
      ST_PAYLOAD: begin
        memEn      = 1'b1;
        memWe      = 1'b1;
        stb.selPay = 1'b1;
        stb.nextPay = 1'b1;
        if (flags.lastPay) nextState = ST_DONE;
      end
      ST_DONE: begin
        done      = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memEn && !aluReq && !done);

endmodule

// File: rtl/cipherSeqData.sv
module cipherSeqData
  import cipherSeqPkg::*;
#(
  parameter int KEY_BYTES = 10,
  parameter int PAY_BYTES = 4,
  parameter int ADDR_W    = 12,
  parameter int CNT_W     = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobes_t              stb,
  input  logic                     cmdVerify,
  input  logic [ADDR_W-1:0]        cmdPtr,
  input  logic [KEY_BYTES*8-1:0]   keyBits,
  input  logic [PAY_BYTES*8-1:0]   payloadBits,
  input  logic [7:0]               memRdata,
  input  logic [7:0]               aluResult,
  output seqFlags_t                flags,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [7:0]               memWdata,
  output logic [7:0]               aluA,
  output logic [7:0]               aluB,
  output logic [CNT_W-1:0]         runCycles,
  output logic [7:0]               verifyAcc,
  output logic                     payloadErr
);

  localparam int BYTE_W   = 8;
  localparam int IDX_W    = $clog2(KEY_BYTES + 1);
  localparam int PIDX_W   = $clog2(PAY_BYTES + 1);
  localparam int MEM_SIZE = 1 << ADDR_W;
  localparam int SPAN     = KEY_BYTES + PAY_BYTES;

  logic [ADDR_W-1:0]          ptrReg;
  logic                       isVerify;
  logic [KEY_BYTES*8-1:0]     keyReg;
  logic [PAY_BYTES*8-1:0]     payReg;
  logic [IDX_W-1:0]           idx;
  logic [PIDX_W-1:0]          payIdx;
  logic [BYTE_W-1:0]          byteReg, resReg, acc;
  logic [CNT_W-1:0]           cnt;
  logic                       errReg;
  logic [ADDR_W:0]            endAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrReg   <= '0;
      isVerify <= 1'b0;
      keyReg   <= '0;
      payReg   <= '0;
      idx      <= '0;
      payIdx   <= '0;
      byteReg  <= '0;
      resReg   <= '0;
      acc      <= '0;
      cnt      <= '0;
      errReg   <= 1'b0;
    end else if (stb.start) begin
      // R8: private copies taken at acceptance
      ptrReg   <= cmdPtr;
      isVerify <= cmdVerify;
      keyReg   <= keyBits;
      payReg   <= payloadBits;
      idx      <= '0;
      payIdx   <= '0;
      acc      <= '0;
      cnt      <= '0;
      errReg   <= 1'b0;
    end else begin
      if (stb.countEn)  cnt <= cnt + CNT_W'(1);
      if (stb.capByte)  byteReg <= memRdata;
      if (stb.capRes) begin
        resReg <= aluResult;
        if (isVerify) acc <= acc | aluResult;  // R3
      end
      if (stb.nextByte) idx <= idx + IDX_W'(1);
      if (stb.nextPay)  payIdx <= payIdx + PIDX_W'(1);
      if (stb.setErr)   errReg <= 1'b1;
    end
  end

  assign endAddr = {1'b0, ptrReg} + (ADDR_W+1)'(SPAN);

  always_comb begin
    flags.verifyMode = isVerify;
    flags.lastByte   = (idx == IDX_W'(KEY_BYTES - 1));
    flags.lastPay    = (payIdx == PIDX_W'(PAY_BYTES - 1));
    flags.accZero    = (acc == '0);
    flags.outOfRange = (endAddr > (ADDR_W+1)'(MEM_SIZE));
  end

  // R2: window addresses wrap modulo the memory size
  assign memAddr  = stb.selPay ? ptrReg + ADDR_W'(KEY_BYTES) + ADDR_W'(payIdx)
                               : ptrReg + ADDR_W'(idx);
  assign memWdata = stb.selPay ? payReg[int'(payIdx)*BYTE_W +: BYTE_W] : resReg;
  assign aluA     = byteReg;
  assign aluB     = keyReg[int'(idx)*BYTE_W +: BYTE_W];

  assign runCycles  = cnt;
  assign verifyAcc  = acc;
  assign payloadErr = errReg;

  assert_err_needs_match_R5: assert property (@(posedge clk) disable iff (!rstN)
    payloadErr |-> verifyAcc == '0);

endmodule

// File: rtl/cipherSeq.sv
module cipherSeq
  import cipherSeqPkg::*;
#(
  parameter int KEY_BYTES = 10,
  parameter int PAY_BYTES = 4,
  parameter int ADDR_W    = 12,
  parameter int CNT_W     = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdValid,
  input  logic                   cmdVerify,
  input  logic [ADDR_W-1:0]      cmdPtr,
  input  logic [KEY_BYTES*8-1:0] keyBits,
  input  logic [PAY_BYTES*8-1:0] payloadBits,
  output logic                   memEn,
  output logic                   memWe,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [7:0]             memWdata,
  input  logic [7:0]             memRdata,
  output logic                   aluReq,
  output logic [7:0]             aluA,
  output logic [7:0]             aluB,
  input  logic                   aluAck,
  input  logic [7:0]             aluResult,
  output logic                   busy,
  output logic                   done,
  output logic [CNT_W-1:0]       runCycles,
  output logic [7:0]             verifyAcc,
  output logic                   payloadErr
);

  seqStrobes_t stb;
  seqFlags_t   flags;

  cipherSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .aluAck(aluAck),
    .flags(flags), .stb(stb), .memEn(memEn), .memWe(memWe),
    .aluReq(aluReq), .busy(busy), .done(done)
  );

  cipherSeqData #(
    .KEY_BYTES(KEY_BYTES), .PAY_BYTES(PAY_BYTES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdVerify(cmdVerify), .cmdPtr(cmdPtr),
    .keyBits(keyBits), .payloadBits(payloadBits), .memRdata(memRdata),
    .aluResult(aluResult), .flags(flags), .memAddr(memAddr), .memWdata(memWdata),
    .aluA(aluA), .aluB(aluB), .runCycles(runCycles), .verifyAcc(verifyAcc),
    .payloadErr(payloadErr)
  );

  assert_alu_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    aluReq && !aluAck |=> aluReq && $stable(aluA) && $stable(aluB));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> runCycles == $past(runCycles) + CNT_W'(1));

endmodule

// File: tb/cipherSeq_test.sv
module cipherSeq_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEMSZ = 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdVerify = 1'b0;
  logic [11:0] cmdPtr = '0;
  logic [79:0] keyBits = '0;
  logic [31:0] payloadBits = '0;
  logic        memEn, memWe, aluReq, aluAck, busy, done, payloadErr;
  logic [11:0] memAddr;
  logic [7:0]  memWdata, memRdata, aluA, aluB, aluResult, verifyAcc;
  logic [15:0] runCycles;

  logic [7:0] mem [MEMSZ];
  logic [7:0] expMem [MEMSZ];
  logic [2:0] aluWait;
  int tests = 0, fails = 0;
  int rdCnt = 0, wrCnt = 0, opCnt = 0, doneCnt = 0, busyCnt = 0;
  bit hung = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cipherSeq uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdVerify(cmdVerify),
    .cmdPtr(cmdPtr), .keyBits(keyBits), .payloadBits(payloadBits),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .aluReq(aluReq), .aluA(aluA), .aluB(aluB),
    .aluAck(aluAck), .aluResult(aluResult), .busy(busy), .done(done),
    .runCycles(runCycles), .verifyAcc(verifyAcc), .payloadErr(payloadErr)
  );

  // operand-dependent latency, 0..3 wait cycles
  function automatic logic [2:0] latOf(input logic [7:0] a, input logic [7:0] b);
    return 3'((a + b) & 8'h3);
  endfunction

  assign aluAck    = aluReq && (aluWait == latOf(aluA, aluB));
  assign aluResult = aluA ^ aluB;

  always @(posedge clk) begin
    if (!rstN || !aluReq || aluAck) aluWait <= '0;
    else aluWait <= aluWait + 3'd1;
    if (memEn) begin
      if (memWe) mem[memAddr] <= memWdata;
      memRdata <= mem[memAddr];
    end
    if (memEn && !memWe) rdCnt <= rdCnt + 1;
    if (memEn && memWe)  wrCnt <= wrCnt + 1;
    if (aluAck) opCnt <= opCnt + 1;
    if (done)   doneCnt <= doneCnt + 1;
    if (busy)   busyCnt <= busyCnt + 1;
  end

  function automatic logic [7:0] keyByte(input logic [79:0] k, input int i);
    return k[i*8 +: 8];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runCmd(input bit ver, input logic [11:0] ptr, input bit poke,
                        input bit rekey);
    int d = 0, expCyc, mism = 0, r0, w0, o0, dn0, b0, n = 0, expW;
    logic [7:0] acc = '0;
    bit expErr = 0;
    logic [79:0] k = keyBits;
    if (hung) return;
    foreach (mem[i]) expMem[i] = mem[i];
    for (int i = 0; i < 10; i++) begin
      int a = (int'(ptr) + i) % MEMSZ;
      d += int'(latOf(mem[a], keyByte(k, i)));
      if (ver) acc |= mem[a] ^ keyByte(k, i);
      else expMem[a] = mem[a] ^ keyByte(k, i);
    end
    if (ver) begin
      expCyc = 32 + d; expW = 0;
      if (acc == 0) begin
        if (int'(ptr) + 14 <= MEMSZ) begin
          for (int j = 0; j < 4; j++) expMem[int'(ptr) + 10 + j] = payloadBits[j*8 +: 8];
          expCyc += 4; expW = 4;
        end else expErr = 1;
      end
    end else begin
      expCyc = 41 + d; expW = 10;
    end
    r0 = rdCnt; w0 = wrCnt; o0 = opCnt; dn0 = doneCnt; b0 = busyCnt;
    @(negedge clk);
    cmdValid = 1'b1; cmdVerify = ver; cmdPtr = ptr;
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy == 1'b1, "R7", "busy after accept", int'(busy), 1);
    while (busy && n < 600) begin
      n++;
      if (rekey && n == 3) keyBits = ~k;
      if (poke && n == 5) begin cmdValid = 1'b1; cmdVerify = 1'b0; cmdPtr = 12'h100; end
      if (poke && n == 6) cmdValid = 1'b0;
      @(negedge clk);
    end
    if (busy) begin
      hung = 1;
      check(0, "R7", "watchdog expired", n, 0);
      return;
    end
    keyBits = k;
    foreach (mem[i]) if (mem[i] !== expMem[i]) mism++;
    check(mism == 0, ver ? (expW != 0 ? "R4" : "R3") : "R2", "memory image mismatches", mism, 0);
    check(int'(runCycles) == expCyc, "R6", "runCycles", int'(runCycles), expCyc);
    check(busyCnt - b0 == expCyc, "R6", "busy cycles", busyCnt - b0, expCyc);
    check(doneCnt - dn0 == 1, "R7", "done pulses", doneCnt - dn0, 1);
    check(rdCnt - r0 == 10 && opCnt - o0 == 10, "R9", "reads+alu ops",
          rdCnt - r0 + opCnt - o0, 20);
    check(wrCnt - w0 == expW, "R9", "writes", wrCnt - w0, expW);
    if (ver) begin
      check(verifyAcc == acc, "R3", "verifyAcc", int'(verifyAcc), int'(acc));
      check(payloadErr == expErr, "R5", "payloadErr", int'(payloadErr), int'(expErr));
    end
  endtask

  task automatic plantKey(input logic [11:0] ptr);
    for (int i = 0; i < 10; i++) mem[(int'(ptr) + i) % MEMSZ] = keyByte(keyBits, i);
  endtask

  initial begin
    void'($urandom(32'd1337));
    foreach (mem[i]) mem[i] = 8'($urandom);
    keyBits = {16'($urandom), $urandom, $urandom};
    payloadBits = $urandom;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !memEn && !memWe && !aluReq && !payloadErr, "R1",
          "control outputs idle", int'({busy, done, memEn, memWe, aluReq, payloadErr}), 0);
    check(runCycles == 0 && verifyAcc == 0, "R1", "counters zero",
          int'(runCycles) + int'(verifyAcc), 0);

    runCmd(0, 12'h200, 0, 0);         // R2 plain encrypt
    runCmd(0, 12'hFFA, 0, 0);         // R2 wrap past 4095
    runCmd(1, 12'h400, 0, 0);         // R3 mismatch, R5 no payload
    plantKey(12'h300);
    runCmd(1, 12'h300, 0, 0);         // R4 match with payload
    plantKey(12'hFF2);
    runCmd(1, 12'hFF2, 0, 0);         // R4 payload ends exactly at 4096
    plantKey(12'hFF3);
    runCmd(1, 12'hFF3, 0, 0);         // R5 one byte beyond: refused
    runCmd(0, 12'h500, 1, 0);         // R7 command during run ignored
    runCmd(0, 12'h600, 0, 1);         // R8 secret changed mid-run
    plantKey(12'h700);
    payloadBits = 32'hA5C3_0F96;
    runCmd(1, 12'h700, 0, 1);         // R8 verify with rekey mid-run

    for (int t = 0; t < 20; t++) begin
      logic [11:0] p = 12'($urandom);
      bit v = 1'($urandom);
      keyBits = {16'($urandom), $urandom, $urandom};
      payloadBits = $urandom;
      if (v && $urandom_range(1, 0) == 1) plantKey(p);
      runCmd(v, p, 0, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule